// File: doc/BRIEF.md
# Vertical Scroll Address Pulse Burst

At the close of each vertical retrace, this block pre-advances the line address counter of the video memory. It issues a short burst of clock pulses on the upper address clock line. Each pulse moves the displayed picture by one memory line, so the length of the burst sets the vertical scroll position. The burst length is a small scroll value that is captured when the trigger is accepted. The burst always occupies a window of fixed length, whatever the count. This keeps the total frame timing identical for every scroll setting.

All activity advances on a tick enable. The pulse width and the window length are therefore counted in ticks rather than in raw clock cycles. Pulses are packed against the end of the window, and idle ticks fill its front. The block's burst is ORed with an externally generated per-line advance pulse, so the two share one address clock line. The address counters themselves live elsewhere.

Top module: `vsb_burst`

## Requirements
- R1: After reset, with the per-line advance input low and no trigger accepted, `addr_clk` and `done` are both 0.
- R2: On a clock edge with `tick_en` = 1 and `trig` = 1 while no window is running, the block captures `scroll`. The first window tick (index 0) is the tick that follows that edge.
- R3: The number of high pulses produced in a window equals the captured scroll value, from 0 to 7 with the default 3-bit width.
- R4: Each pulse is high for exactly one tick and is followed by at least one low tick. With N the captured value, the pulses occupy window ticks 16-2N, 16-2N+2, ..., 14. All earlier ticks are low padding.
- R5: A window is exactly 16 ticks long for every scroll value. `done` is 1 during window tick 15 only.
- R6: A trigger presented during any tick of a running window, including tick 15, is ignored. The running pattern is unchanged, and no new window follows from it.
- R7: Changes on `scroll` after the capture edge do not alter the running burst.
- R8: `addr_clk` is the OR of the burst and the `line_adv` input. When `line_adv` is 1, `addr_clk` is 1.
- R9: The window state advances only on clock edges with `tick_en` = 1. With `tick_en` = 0, outputs and state hold, and a trigger is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Tick enable; one window tick per enabled edge |
| trig | input | 1 | Start request issued after the last short retrace sync |
| scroll | input | CNT_W (3) | Scroll amount, sampled on the accepted trigger |
| line_adv | input | 1 | Per-line address advance pulse from the line timing logic |
| addr_clk | output | 1 | Upper video memory address clock (burst OR line_adv) |
| done | output | 1 | High during the final tick of the window |

## Verification
The bound checker watches several properties on every cycle. It checks that a pulse is always followed by a low tick. It checks that `done` lasts one tick and ends the window. It checks that a running window cannot be cut short or restarted. It checks that nothing moves without `tick_en`, and that the pulses counted in a window match the captured value. Other behaviours can only be shown by the bench's scenarios. These are the exact placement of the pulses against the end of the window and the immunity to scroll changes after capture. They also include the single idle tick that separates back-to-back windows when the trigger is held, and correct timing under sparse tick enables.

// File: rtl/vsb_pkg.sv
package vsb_pkg;

   // index of the first pulse tick inside a window of win ticks holding n pulses
   function automatic int unsigned first_pulse_tick(int unsigned win, int unsigned n);
      return win - 2 * n;
   endfunction

   // largest burst a count field of w bits can request
   function automatic int unsigned max_burst(int unsigned w);
      return (1 << w) - 1;
   endfunction

endpackage

// File: rtl/vsb_window_seq.sv
module vsb_window_seq #(
   parameter int unsigned WIN_LEN = 16,
   parameter int unsigned CNT_W   = 3,
   localparam int unsigned POS_W  = $clog2(WIN_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             trig,
   input  logic [CNT_W-1:0] scroll,
   output logic             busy,
   output logic [POS_W-1:0] pos,
   output logic [CNT_W-1:0] count,
   output logic             last
);

   localparam logic [POS_W-1:0] LAST_POS = POS_W'(WIN_LEN - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         pos   <= '0;
         count <= '0;
      end else if (tick_en) begin
         if (!busy) begin
            if (trig) begin
               busy  <= 1'b1;
               pos   <= '0;
               count <= scroll;
            end
         end else if (pos == LAST_POS) begin
            busy <= 1'b0;
            pos  <= '0;
         end else begin
            pos <= pos + 1'b1;
         end
      end
   end

   assign last = busy && (pos == LAST_POS);

endmodule

// File: rtl/vsb_pulse_dec.sv
module vsb_pulse_dec #(
   parameter int unsigned WIN_LEN = 16,
   parameter int unsigned CNT_W   = 3,
   localparam int unsigned POS_W  = $clog2(WIN_LEN)
) (
   input  logic             busy,
   input  logic [POS_W-1:0] pos,
   input  logic [CNT_W-1:0] count,
   output logic             pulse
);

   localparam logic [POS_W:0] WIN_V = (POS_W+1)'(WIN_LEN);

   logic [POS_W:0] start_tick;
   logic [POS_W:0] pos_x;
   logic [POS_W:0] offset;

   always_comb begin
      start_tick = WIN_V - (POS_W+1)'({count, 1'b0});
      pos_x      = {1'b0, pos};
      offset     = pos_x - start_tick;
      pulse      = busy && (pos_x >= start_tick) && !offset[0];
   end

endmodule

// File: rtl/vsb_burst.sv
module vsb_burst #(
   parameter int unsigned WIN_LEN = 16,
   parameter int unsigned CNT_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             trig,
   input  logic [CNT_W-1:0] scroll,
   input  logic             line_adv,
   output logic             addr_clk,
   output logic             done
);

   import vsb_pkg::*;

   localparam int unsigned POS_W    = $clog2(WIN_LEN);
   localparam int unsigned MAX_N    = max_burst(CNT_W);
   localparam int unsigned MIN_FREE = first_pulse_tick(WIN_LEN, MAX_N);

   generate
      if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt_w
         initial $fatal(1, "vsb_burst: CNT_W must lie in 1..8");
      end
      if (WIN_LEN < 2 * MAX_N || WIN_LEN < 2) begin : g_bad_win
         initial $fatal(1, "vsb_burst: WIN_LEN too short for the largest burst");
      end
      if (MIN_FREE > WIN_LEN) begin : g_bad_pad
         initial $fatal(1, "vsb_burst: padding computation out of range");
      end
   endgenerate

   logic             seq_busy;
   logic [POS_W-1:0] seq_pos;
   logic [CNT_W-1:0] seq_count;
   logic             seq_last;
   logic             burst_pulse;

   vsb_window_seq #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .trig    (trig),
      .scroll  (scroll),
      .busy    (seq_busy),
      .pos     (seq_pos),
      .count   (seq_count),
      .last    (seq_last)
   );

   vsb_pulse_dec #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_dec (
      .busy  (seq_busy),
      .pos   (seq_pos),
      .count (seq_count),
      .pulse (burst_pulse)
   );

   assign addr_clk = burst_pulse | line_adv;
   assign done     = seq_last;

endmodule

// File: rtl/vsb_burst_chk.sv
module vsb_burst_chk #(
   parameter int unsigned CNT_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_en,
   input logic             trig,
   input logic [CNT_W-1:0] scroll,
   input logic             line_adv,
   input logic             busy,
   input logic             burst,
   input logic             done,
   input logic             addr_clk
);

   logic [CNT_W:0]   seen;
   logic [CNT_W-1:0] want;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen <= '0;
         want <= '0;
      end else if (tick_en) begin
         if (!busy && trig) begin
            seen <= '0;
            want <= scroll;
         end else if (busy && burst) begin
            seen <= seen + 1'b1;
         end
      end
   end

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !line_adv) |-> !addr_clk);

   p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && trig && tick_en) |=> busy);

   p_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && tick_en) |-> (seen == {1'b0, want}));

   p_pulse_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (burst && tick_en) |=> !burst);

   p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && tick_en) |=> (!done && !busy));

   p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   p_adv_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      line_adv |-> addr_clk);

   p_tick_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> ($stable(busy) && $stable(burst) && $stable(done)));

endmodule

bind vsb_burst vsb_burst_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_en  (tick_en),
   .trig     (trig),
   .scroll   (scroll),
   .line_adv (line_adv),
   .busy     (seq_busy),
   .burst    (burst_pulse),
   .done     (done),
   .addr_clk (addr_clk)
);

// File: tb/sim_vsb_burst.sv
module sim_vsb_burst;

   localparam int WIN = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       trig = 1'b0;
   logic [2:0] scroll = 3'd0;
   logic       line_adv = 1'b0;
   logic       addr_clk;
   logic       done;

   int checks = 0;
   int errors = 0;

   // entry: [7:5] scroll value, [4:0] window tick carrying line_adv (31 = none)
   localparam logic [7:0] VEC [12] = '{
      {3'd0, 5'd31}, {3'd1, 5'd31}, {3'd2, 5'd31}, {3'd3, 5'd31},
      {3'd4, 5'd31}, {3'd5, 5'd31}, {3'd6, 5'd31}, {3'd7, 5'd31},
      {3'd0, 5'd4},  {3'd3, 5'd11}, {3'd7, 5'd0},  {3'd5, 5'd15}
   };

   vsb_burst u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .trig     (trig),
      .scroll   (scroll),
      .line_adv (line_adv),
      .addr_clk (addr_clk),
      .done     (done)
   );

   always #10ns clk = ~clk;

   function automatic logic exp_hi(int k, int n);
      int st;
      st = WIN - 2 * n;
      return (k >= st) && (((k - st) % 2) == 0);
   endfunction

   task automatic check(logic ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // runs one window with tick_en always high; trig_at/trig_val inject a trigger at a tick
   task automatic run_window(int n, int adv_at, int trig_at);
      int rises = 0;
      logic prev = 1'b0;
      @(negedge clk);
      tick_en = 1'b1; trig = 1'b1; scroll = 3'(n);
      @(posedge clk);
      @(negedge clk);
      trig = 1'b0;
      scroll = ~3'(n);                       // R7: later scroll changes must not matter
      for (int k = 0; k < WIN; k++) begin
         line_adv = (k == adv_at);
         trig = (k == trig_at);
         scroll = (k == trig_at) ? 3'd7 - 3'(n) : scroll;
         #1ns;
         check(addr_clk == (exp_hi(k, n) | line_adv), "R4/R8 addr_clk at tick",
               int'(addr_clk), int'(exp_hi(k, n) | line_adv));
         check(done == (k == WIN - 1), "R5 done at tick", int'(done), int'(k == WIN - 1));
         if (exp_hi(k, n) && !line_adv && addr_clk && !prev) rises++;
         prev = addr_clk & !line_adv;
         @(posedge clk);
         @(negedge clk);
      end
      line_adv = 1'b0;
      trig = 1'b0;
      check(rises == n, "R3 pulse count", rises, n);
      for (int j = 0; j < 3; j++) begin
         #1ns;
         check(!addr_clk && !done, "R6 idle after window", int'(addr_clk | done), 0);
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   // window with sparse tick enables: state must move only on enabled edges
   task automatic run_gated(int n);
      int ep = 0;
      int cyc = 0;
      @(negedge clk);
      tick_en = 1'b1; trig = 1'b1; scroll = 3'(n);
      @(posedge clk);
      @(negedge clk);
      trig = 1'b0;
      while (ep < WIN) begin
         tick_en = (cyc % 3) == 0;
         #1ns;
         check(addr_clk == exp_hi(ep, n), "R9 gated addr_clk", int'(addr_clk), int'(exp_hi(ep, n)));
         check(done == (ep == WIN - 1), "R9 gated done", int'(done), int'(ep == WIN - 1));
         @(posedge clk);
         if (tick_en) ep++;
         cyc++;
         @(negedge clk);
      end
      tick_en = 1'b1;
      #1ns;
      check(!done && !addr_clk, "R9 gated window ended", int'(done | addr_clk), 0);
   endtask

   initial begin
      #4ms;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      int seen_done;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      tick_en = 1'b1;
      for (int j = 0; j < 4; j++) begin
         #1ns;
         check(!addr_clk && !done, "R1 quiet after reset", int'(addr_clk | done), 0);
         @(negedge clk);
      end

      // R2/R3/R4/R5/R7/R8 table walk
      for (int v = 0; v < 12; v++)
         run_window(int'(VEC[v][7:5]), int'(VEC[v][4:0]), -1);

      // R6: trigger in mid window and in the last tick
      run_window(2, 31, 5);
      run_window(6, 31, 15);

      // R9: trigger without tick enable is not accepted
      @(negedge clk);
      tick_en = 1'b0; trig = 1'b1; scroll = 3'd4;
      repeat (3) @(negedge clk);
      trig = 1'b0; tick_en = 1'b1;
      seen_done = 0;
      for (int j = 0; j < 20; j++) begin
         #1ns;
         if (done) seen_done++;
         @(negedge clk);
      end
      check(seen_done == 0, "R9 trigger without tick ignored", seen_done, 0);

      // R9: sparse ticks
      run_gated(3);
      run_gated(7);

      finish_run();
   end

endmodule